// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped controller for thirteen general-purpose pins. The pins fall into three banks of seven, four and two pins. A byte-wide synchronous bus reads and writes the registers. Each pin has an output control register that sets its output level, direction, drive type and pull configuration. These reach the pad logic as plain signals. Each pin also has an input control register. It returns the synchronized pin level and holds a two-bit field that chooses which edges raise an interrupt.

Pin inputs pass through a two-flop synchronizer. An edge is a difference between the current and previous synchronized samples. When a pin's detect mode matches the edge, the pin's pending bit is latched in one of two interrupt groups. Group 0 covers pins 0 to 6 and group 1 covers pins 7 to 12. Each group has a status register, where writing 1 clears a bit, and a mask register, where 1 suppresses the pin. A single interrupt output is high while any pending bit is unmasked.

Register map (byte addresses):
- Output control of pin p: address p (0x00 to 0x0C).
- Input control of pin p: address 13+p (0x0D to 0x19).
- Status: group 0 at 0x20, group 1 at 0x21.
- Mask: group 0 at 0x28, group 1 at 0x29.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input, open-drain, with output level 0 and the pull disabled. Detection is off on every pin, both mask registers hold all ones (0x7F and 0x3F), all status bits are clear and irq is low.
- R2: Output control register of pin p, at address p, drives that pin's pads as follows:
  - bit 0 drives pin_out[p];
  - bits 2:1 drive pin_pull_sel[2p+1:2p] (0 strong down, 1 strong up, 2 weak down, 3 weak up);
  - bit 3 drives pin_pull_en[p];
  - bit 4 drives pin_push_pull[p] (1 push-pull, 0 open-drain);
  - bit 5 drives pin_oe[p] (1 output).
  The register reads back bits 5:0, and bits 7:6 read 0.
- R3: Input control register of pin p is at address 13+p. It reads {5'b0, detect[1:0], level}, where level is the synchronized value of pin_in[p]. Only bits 2:1 are writable.
- R4: Detect value 1 (falling) sets the pin's pending bit on a 1-to-0 input change and not on a 0-to-1 change.
- R5: Detect value 2 (rising) sets the pending bit on a 0-to-1 change only.
- R6: Detect value 3 sets the pending bit on both edges. Value 0 never sets it.
- R7: Pins 0 to 6 report at bits 6:0 of status 0x20 and mask 0x28. Pins 7 to 12 report at bits 5:0 of status 0x21 and mask 0x29.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: An edge after a clear sets the bit again. An edge detected in the same cycle as a clear write leaves the bit set.
- R10: irq is high exactly when some status bit is set and its mask bit is 0. Masking a pin does not stop its status bit from latching.
- R11: Unused upper bits of the group registers read 0. Writes to them are ignored.
- R12: reg_rdata loads the addressed register on the clock edge that samples reg_ren and holds otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| pin_in | input | 13 | Raw pin levels |
| pin_out | output | 13 | Output level per pin |
| pin_oe | output | 13 | Output enable (direction) per pin |
| pin_push_pull | output | 13 | 1 push-pull, 0 open-drain |
| pin_pull_en | output | 13 | Pull resistor enable |
| pin_pull_sel | output | 26 | Pull selection, two bits per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: thirteen pins split into a seven-bit group and a six-bit group. With this split, both groups leave unused upper bits: bit 7 of group 0 and bits 7:6 of group 1. The bench therefore exercises padding on both sides, and pin 7 sits at the group boundary. Directed cases cover each detect mode, a clear and an edge landing in the same cycle, and masking a pending bit. Random pin toggles, detect and mask writes and clears then run against a reference model.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [1:0] {
        DET_OFF  = 2'd0,
        DET_FALL = 2'd1,
        DET_RISE = 2'd2,
        DET_BOTH = 2'd3
    } det_mode_e;

    // field order matches the output control register, MSB first
    typedef struct packed {
        logic       dir_out;
        logic       push_pull;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       level;
    } pad_ctrl_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl_i,
    input  logic [2*W-1:0] mode_i,
    output logic [W-1:0]   evt_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        det_mode_e mode;
        logic      rise, fall, hit;

        assign mode = det_mode_e'(mode_i[2*i +: 2]);
        assign rise = lvl_i[i] & ~prev_q[i];
        assign fall = ~lvl_i[i] & prev_q[i];

        always_comb begin
            unique case (mode)
                DET_OFF:  hit = 1'b0;
                DET_FALL: hit = fall;
                DET_RISE: hit = rise;
                DET_BOTH: hit = rise | fall;
                default:  hit = 1'b0;
            endcase
        end
        assign evt_o[i] = hit;

        // R6: a disabled pin never reports an event
        p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[i] |-> (mode != DET_OFF));
        // R5: a rising-only event happens with the level now high
        p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_o[i] && mode == DET_RISE) |-> lvl_i[i]);
        // R4: a falling-only event happens with the level now low
        p_fall_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_o[i] && mode == DET_FALL) |-> !lvl_i[i]);
    end
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         stat_wr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] clr;

    assign clr = stat_wr_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
            mask_o <= '1;
        end else begin
            // a new event outranks a clear in the same cycle
            stat_o <= (stat_o & ~clr) | evt_i;
            if (mask_wr_i) mask_o <= wdata_i;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        // R9: a pending bit only rises after an event
        p_set_by_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_o[i]) |-> $past(evt_i[i]));
        // R8: a pending bit only falls after a write of 1 to it
        p_fall_by_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_o[i]) |-> $past(stat_wr_i && wdata_i[i]));
        // R8: a clear with no competing event empties the bit
        p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr_i && wdata_i[i] && !evt_i[i]) |=> !stat_o[i]);
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int              NUM_PINS  = 13,
    parameter int              GRP0_PINS = 7,
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h28
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wen,
    input  logic                  reg_ren,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_push_pull,
    output logic [NUM_PINS-1:0]   pin_pull_en,
    output logic [2*NUM_PINS-1:0] pin_pull_sel,
    output logic                  irq
);
    localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
    localparam int IN_BASE   = NUM_PINS;
    localparam int CTRL_W    = $bits(pad_ctrl_t);

    logic [NUM_PINS-1:0]   lvl, evt;
    logic [2*NUM_PINS-1:0] det_flat;
    pad_ctrl_t             out_q [NUM_PINS];
    logic [1:0]            det_q [NUM_PINS];
    logic [GRP0_PINS-1:0]  stat0, mask0;
    logic [GRP1_PINS-1:0]  stat1, mask1;
    logic                  wr_stat0, wr_stat1, wr_mask0, wr_mask1;
    logic [DATA_W-1:0]     rd_next;

    assign wr_stat0 = reg_wen && (reg_addr == STAT_ADDR);
    assign wr_stat1 = reg_wen && (reg_addr == STAT_ADDR + 1'b1);
    assign wr_mask0 = reg_wen && (reg_addr == MASK_ADDR);
    assign wr_mask1 = reg_wen && (reg_addr == MASK_ADDR + 1'b1);

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (lvl)
    );

    gpio_edge_detect #(.W(NUM_PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .mode_i (det_flat),
        .evt_o  (evt)
    );

    gpio_irq_group #(.W(GRP0_PINS)) u_grp0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt[GRP0_PINS-1:0]),
        .stat_wr_i (wr_stat0),
        .mask_wr_i (wr_mask0),
        .wdata_i   (reg_wdata[GRP0_PINS-1:0]),
        .stat_o    (stat0),
        .mask_o    (mask0)
    );

    gpio_irq_group #(.W(GRP1_PINS)) u_grp1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt[NUM_PINS-1:GRP0_PINS]),
        .stat_wr_i (wr_stat1),
        .mask_wr_i (wr_mask1),
        .wdata_i   (reg_wdata[GRP1_PINS-1:0]),
        .stat_o    (stat1),
        .mask_o    (mask1)
    );

    // per-pin control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                out_q[p] <= '0;
                det_q[p] <= DET_OFF;
            end
        end else if (reg_wen) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (reg_addr == ADDR_W'(p))
                    out_q[p] <= pad_ctrl_t'(reg_wdata[CTRL_W-1:0]);
                if (reg_addr == ADDR_W'(IN_BASE + p))
                    det_q[p] <= reg_wdata[2:1];
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
        assign pin_out[p]             = out_q[p].level;
        assign pin_oe[p]              = out_q[p].dir_out;
        assign pin_push_pull[p]       = out_q[p].push_pull;
        assign pin_pull_en[p]         = out_q[p].pull_en;
        assign pin_pull_sel[2*p +: 2] = out_q[p].pull_sel;
        assign det_flat[2*p +: 2]     = det_q[p];
    end

    // read mux
    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (reg_addr == ADDR_W'(p))
                rd_next[CTRL_W-1:0] = out_q[p];
            if (reg_addr == ADDR_W'(IN_BASE + p))
                rd_next[2:0] = {det_q[p], lvl[p]};
        end
        if (reg_addr == STAT_ADDR)        rd_next[GRP0_PINS-1:0] = stat0;
        if (reg_addr == STAT_ADDR + 1'b1) rd_next[GRP1_PINS-1:0] = stat1;
        if (reg_addr == MASK_ADDR)        rd_next[GRP0_PINS-1:0] = mask0;
        if (reg_addr == MASK_ADDR + 1'b1) rd_next[GRP1_PINS-1:0] = mask1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       reg_rdata <= '0;
        else if (reg_ren) reg_rdata <= rd_next;
    end

    assign irq = |(stat0 & ~mask0) | |(stat1 & ~mask1);

    // R11: group 1 reads never show bits above its width
    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ren && (reg_addr == STAT_ADDR + 1'b1 || reg_addr == MASK_ADDR + 1'b1))
        |=> (reg_rdata[DATA_W-1:GRP1_PINS] == '0));
    // R2: a write to pin 0's output control reaches its pads next cycle
    p_out_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == '0)
        |=> (pin_out[0] == $past(reg_wdata[0]) && pin_oe[0] == $past(reg_wdata[5])));
    // R10: irq rises only after an event or a mask change
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|evt) || wr_mask0 || wr_mask1));
    // R12: read data holds while no read is issued
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_ren |=> $stable(reg_rdata));
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb_top;
    localparam int N = 13;
    localparam logic [7:0] ST0 = 8'h20, ST1 = 8'h21, MK0 = 8'h28, MK1 = 8'h29;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          reg_wen = 0, reg_ren = 0;
    logic [7:0]    reg_addr = '0, reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, pin_push_pull, pin_pull_en;
    logic [2*N-1:0] pin_pull_sel;
    logic          irq;

    int checks = 0, fails = 0, cycles = 0;

    // reference model
    logic [5:0]   m_out [N];
    logic [1:0]   m_det [N];
    logic [N-1:0] m_stat = '0, m_mask = '1;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_ren(reg_ren),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_push_pull(pin_push_pull), .pin_pull_en(pin_pull_en),
        .pin_pull_sel(pin_pull_sel), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wen = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 0;
        if (a < 8'(N)) m_out[a] = d[5:0];
        else if (a < 8'(2*N)) m_det[a-8'(N)] = d[2:1];
        else if (a == ST0) m_stat[6:0] = m_stat[6:0] & ~d[6:0];
        else if (a == ST1) m_stat[12:7] = m_stat[12:7] & ~d[5:0];
        else if (a == MK0) m_mask[6:0] = d[6:0];
        else if (a == MK1) m_mask[12:7] = d[5:0];
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_ren = 1; reg_addr = a;
        @(negedge clk);
        reg_ren = 0;
        d = reg_rdata;
    endtask

    function automatic logic [N-1:0] edges(logic [N-1:0] o, logic [N-1:0] n);
        logic [N-1:0] e = '0;
        for (int p = 0; p < N; p++) begin
            if (o[p] != n[p]) begin
                if (n[p] && m_det[p][1]) e[p] = 1'b1;
                if (!n[p] && m_det[p][0]) e[p] = 1'b1;
            end
        end
        return e;
    endfunction

    function automatic logic exp_irq();
        return |(m_stat & ~m_mask);
    endfunction

    task automatic set_pins(logic [N-1:0] v);
        logic [N-1:0] e;
        @(negedge clk);
        e = edges(pin_in, v);
        pin_in = v;
        repeat (3) @(negedge clk);
        m_stat |= e;
    endtask

    task automatic chk_status(string tag);
        logic [7:0] d;
        rd(ST0, d); chk({tag, " status0"}, d, {1'b0, m_stat[6:0]});
        rd(ST1, d); chk({tag, " status1"}, d, {2'b0, m_stat[12:7]});
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        for (int p = 0; p < N; p++) begin m_out[p] = '0; m_det[p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pin_oe, '0);
        chk("R1 pull_en", pin_pull_en, '0);
        chk("R1 push_pull", pin_push_pull, '0);
        chk("R1 irq", irq, 0);
        rd(MK0, d); chk("R1 mask0", d, 8'h7F);
        rd(MK1, d); chk("R1 mask1", d, 8'h3F);
        chk_status("R1");
        rd(8'd13, d); chk("R1 input reg pin0", d, 8'h00);
        // R12 unmapped address
        rd(8'h40, d); chk("R12 unmapped", d, 8'h00);

        // R2 output fields
        wr(8'd3, 8'hFF);
        chk("R2 out", pin_out[3], 1); chk("R2 oe", pin_oe[3], 1);
        chk("R2 pp", pin_push_pull[3], 1); chk("R2 pull_en", pin_pull_en[3], 1);
        chk("R2 pull_sel", pin_pull_sel[7:6], 2'd3);
        rd(8'd3, d); chk("R2 readback", d, 8'h3F);
        wr(8'd3, 8'h12);
        chk("R2 pull_sel up", pin_pull_sel[7:6], 2'd1);
        chk("R2 oe off", pin_oe[3], 0); chk("R2 pull off", pin_pull_en[3], 0);

        // R3 input reg
        set_pins(13'h0020);
        rd(8'd18, d); chk("R3 level", d, 8'h01);
        wr(8'd18, 8'hFF);
        rd(8'd18, d); chk("R3 detect field", d, 8'h07);
        wr(8'd18, 8'h00);
        set_pins(13'h0000);
        wr(MK0, 8'h00); wr(MK1, 8'h00);

        // R4 falling on pin 1
        wr(8'd14, 8'h02);
        set_pins(13'h0002);
        chk_status("R4 rise ignored");
        chk("R4 irq quiet", irq, 0);
        set_pins(13'h0000);
        chk_status("R4 fall");
        chk("R4 irq", irq, 1);

        // R8 write-one-to-clear
        wr(ST0, 8'h00); chk_status("R8 zero write");
        wr(ST0, 8'h02); chk_status("R8 clear");
        chk("R8 irq low", irq, 0);

        // R5 rising on pin 9, R7 group 1 position
        wr(8'd22, 8'h04);
        set_pins(13'h0200);
        rd(ST1, d); chk("R5 R7 pin9 bit2", d, 8'h04);
        wr(ST1, 8'h3F);
        set_pins(13'h0000);
        chk_status("R5 fall ignored");

        // R6 both on pin 12, pin 11 disabled
        wr(8'd25, 8'h06);
        set_pins(13'h1800);
        chk_status("R6 rise");
        wr(ST1, 8'h20);
        set_pins(13'h0000);
        chk_status("R6 fall");

        // R10 masking keeps status, drops irq
        wr(MK1, 8'h20);
        chk("R10 masked irq", irq, 0);
        chk_status("R10 still latched");
        wr(MK1, 8'h00);
        chk("R10 unmasked irq", irq, 1);
        wr(ST1, 8'h3F);

        // R9 edge and clear in the same cycle; pin1 falling, bit pending
        set_pins(13'h0002);
        set_pins(13'h0000);
        chk_status("R9 pending");
        set_pins(13'h0002);
        @(negedge clk); pin_in = 13'h0000;
        @(negedge clk); @(negedge clk);
        reg_wen = 1; reg_addr = ST0; reg_wdata = 8'h02;
        @(negedge clk); reg_wen = 0;
        chk_status("R9 edge beats clear");
        wr(ST0, 8'h02);
        chk_status("R9 cleared");
        set_pins(13'h0002); set_pins(13'h0000);
        chk_status("R9 set again");

        // R11 upper bits
        wr(MK0, 8'hFF); rd(MK0, d); chk("R11 mask0", d, 8'h7F);
        wr(MK1, 8'hFF); rd(MK1, d); chk("R11 mask1", d, 8'h3F);
        wr(ST0, 8'h80); chk_status("R11 status bit7 write");

        // random phase
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 4);
            int p  = $urandom_range(0, N-1);
            case (op)
                0: set_pins(pin_in ^ N'($urandom));
                1: wr(8'(N + p), 8'($urandom));
                2: wr($urandom_range(0, 1) ? MK0 : MK1, 8'($urandom));
                3: wr($urandom_range(0, 1) ? ST0 : ST1, 8'($urandom));
                default: begin
                    wr(8'(p), 8'($urandom));
                    chk("R2 rand out", {pin_oe[p], pin_push_pull[p], pin_pull_en[p],
                        pin_pull_sel[2*p +: 2], pin_out[p]}, m_out[p]);
                end
            endcase
            chk("R10 rand irq", irq, exp_irq());
            if (it % 4 == 0) chk_status("R7 R4 R5 R6 rand");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule